// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block produces a slower, register-driven clock from one source clock by counting source cycles. It has three division modes. In half-rate mode the output toggles on every source cycle. In binary mode a free-running counter runs and one selectable bit of it sets the output, so the division is a power of two. In integer mode the output stays low for a programmed number of cycles and then high for a programmed number of cycles, and the pattern repeats.

Each output period is a low phase followed by a high phase. The block samples mode, tap and both phase counts only on the last cycle of a period, so settings may change at any time and never cut a phase short. A second output gives a one-cycle pulse in the first high cycle of every period. Logic downstream can use that pulse as a clock enable instead of using the divided clock as a clock.

Top module: `prog_clk_div`

## Requirements
- R1: While `rst_ni` is low, `clk_div_o` and `rise_o` are 0, and this takes effect at once, even in the middle of a period. After release the block spends one cycle with the output low to sample its settings, and the first low phase then follows. The first low run therefore lasts the low count plus one cycle.
- R2: With `mode_i` = 0 the output alternates every source cycle (1 cycle low, 1 cycle high), whatever `hi_i`, `lo_i` and `tap_i` hold.
- R3: With `mode_i` = 1 and `tap_i` = k, the output stays low for 2^k cycles and high for 2^k cycles, so the period is 2^(k+1) source cycles.
- R4: With `mode_i` = 2 or 3 the output stays low for `lo_i` cycles and then high for `hi_i` cycles, and repeats.
- R5: A phase count of 0 acts as 1, so every phase lasts at least one source cycle.
- R6: Settings are taken only on the last high cycle of a period. A change during a low or high phase leaves the rest of the current period on the old values, and the new values apply from the next low phase onward.
- R7: `rise_o` is 1 for exactly one cycle: the first cycle in which `clk_div_o` is high after being low. It is 0 on every other cycle.
- R8: In binary mode a change of tap restarts the counter at zero at the period boundary, so the first period on the new tap has full-length phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, released synchronously by the surrounding logic |
| mode_i | input | 2 | 0 half-rate, 1 binary tap, 2 or 3 integer counts |
| tap_i | input | TAP_W | Counter bit used in binary mode |
| hi_i | input | CNT_W | High-phase length in integer mode |
| lo_i | input | CNT_W | Low-phase length in integer mode |
| clk_div_o | output | 1 | Divided clock, driven straight from a flop |
| rise_o | output | 1 | One-cycle pulse in the first high cycle of each period |

## Verification
A wrong phase counter or active setting appears as a high run or low run of the wrong length. It is visible within the first full period after the fault. A settings register that loads at the wrong moment shows up one period early: a run takes its length from the new values while the old ones should still apply. A pulse register that is off by a cycle is seen on the very next rising edge of the output as a mismatch between `rise_o` and the edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    DIVM_HALF = 2'd0,
    DIVM_POW2 = 2'd1,
    DIVM_INT  = 2'd2,
    DIVM_INTB = 2'd3
  } div_mode_e;
endpackage

// File: rtl/clkdiv_cfg.sv
// Active-settings register: loads a new mode, tap and phase counts
// only when the core signals a period boundary; zero counts become one.
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output div_mode_e        mode_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  div_mode_e        mode_q, mode_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    mode_d = mode_q;
    tap_d  = tap_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (load_i) begin
      mode_d = div_mode_e'(mode_i);
      tap_d  = tap_i;
      hi_d   = (hi_i == '0) ? ONE : hi_i;
      lo_d   = (lo_i == '0) ? ONE : lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DIVM_HALF;
      tap_q  <= '0;
      hi_q   <= ONE;
      lo_q   <= ONE;
    end else begin
      mode_q <= mode_d;
      tap_q  <= tap_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign mode_o = mode_q;
  assign tap_o  = tap_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/clkdiv_core.sv
// Shared counter and output flop for all three division modes.
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CTR_W = 16,
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  div_mode_e        mode_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             out_o,
  output logic             out_nxt_o,
  output logic             load_o,
  output logic             init_o,
  output logic [CTR_W-1:0] cnt_o
);
  localparam int IDX_W   = (CTR_W > 1) ? $clog2(CTR_W) : 1;
  localparam int TOP_BIT = CTR_W - 1;
  localparam logic [CTR_W-1:0] CONE = CTR_W'(1);

  logic [CTR_W-1:0] cnt_q, cnt_d, mask, hi_last, lo_last;
  logic [IDX_W-1:0] tap_c;
  logic             out_q, out_d, init_q, phase_end, load;

  always_comb begin
    tap_c   = (32'(tap_i) > 32'(TOP_BIT)) ? IDX_W'(TOP_BIT) : IDX_W'(tap_i);
    mask    = {CTR_W{1'b1}} >> (IDX_W'(TOP_BIT) - tap_c);
    hi_last = CTR_W'(hi_i) - CONE;
    lo_last = CTR_W'(lo_i) - CONE;

    phase_end = 1'b0;
    cnt_d     = cnt_q;
    out_d     = out_q;
    case (mode_i)
      DIVM_HALF: begin
        phase_end = out_q;
        out_d     = ~out_q;
        cnt_d     = '0;
      end
      DIVM_POW2: begin
        phase_end = ((cnt_q & mask) == mask);
        cnt_d     = cnt_q + CONE;
        out_d     = cnt_d[tap_c];
      end
      default: begin
        if (out_q) begin
          if (cnt_q == hi_last) phase_end = 1'b1;
          else                  cnt_d = cnt_q + CONE;
        end else if (cnt_q == lo_last) begin
          out_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CONE;
        end
      end
    endcase

    load = init_q | phase_end;
    if (load) begin
      cnt_d = '0;
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      init_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      init_q <= 1'b0;
    end
  end

  assign out_o     = out_q;
  assign out_nxt_o = out_d;
  assign load_o    = load;
  assign init_o    = init_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/clkdiv_rise.sv
// Registered rising-edge pulse, aligned with the first high cycle.
module clkdiv_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic out_q_i,
  input  logic out_nxt_i,
  output logic rise_o
);
  logic rise_q, rise_d;

  always_comb rise_d = out_nxt_i & ~out_q_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div
  import clkdiv_pkg::*;
#(
  parameter  int CNT_W = 8,
  parameter  int CTR_W = 16,
  localparam int TAP_W = (CTR_W > 1) ? $clog2(CTR_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             clk_div_o,
  output logic             rise_o
);
  div_mode_e        act_mode;
  logic [TAP_W-1:0] act_tap;
  logic [CNT_W-1:0] act_hi, act_lo;
  logic [CTR_W-1:0] cnt_w;
  logic             load_w, init_w, out_w, out_nxt_w;

  clkdiv_cfg #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_cfg (
    .clk(clk_i), .rst_n(rst_ni), .load_i(load_w),
    .mode_i(mode_i), .tap_i(tap_i), .hi_i(hi_i), .lo_i(lo_i),
    .mode_o(act_mode), .tap_o(act_tap), .hi_o(act_hi), .lo_o(act_lo)
  );

  clkdiv_core #(.CNT_W(CNT_W), .CTR_W(CTR_W), .TAP_W(TAP_W)) u_core (
    .clk(clk_i), .rst_n(rst_ni),
    .mode_i(act_mode), .tap_i(act_tap), .hi_i(act_hi), .lo_i(act_lo),
    .out_o(out_w), .out_nxt_o(out_nxt_w), .load_o(load_w),
    .init_o(init_w), .cnt_o(cnt_w)
  );

  clkdiv_rise u_rise (
    .clk(clk_i), .rst_n(rst_ni),
    .out_q_i(out_w), .out_nxt_i(out_nxt_w), .rise_o(rise_o)
  );

  assign clk_div_o = out_w;
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CTR_W = 16,
  parameter int TAP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_o,
  input logic             rise_o,
  input div_mode_e        act_mode,
  input logic [TAP_W-1:0] act_tap,
  input logic [CNT_W-1:0] act_hi,
  input logic [CNT_W-1:0] act_lo,
  input logic             init_q,
  input logic [CTR_W-1:0] cnt_q
);
  AST_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (!out_o && !rise_o)); // R1

  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == DIVM_HALF && !$past(init_q)) |-> (out_o != $past(out_o))); // R2

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode[1] && out_o) |-> (cnt_q < CTR_W'(act_hi))); // R4

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode[1] && !out_o && !init_q) |-> (cnt_q < CTR_W'(act_lo))); // R4

  AST_NONZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi != '0) && (act_lo != '0)); // R5

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_mode, act_tap, act_hi, act_lo}) |-> ($fell(out_o) || $past(init_q))); // R6

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_o) |-> rise_o); // R7

  AST_RISE_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $rose(out_o)); // R7

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R7
endmodule

bind prog_clk_div clkdiv_chk #(.CNT_W(CNT_W), .CTR_W(CTR_W), .TAP_W(TAP_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .out_o(clk_div_o), .rise_o(rise_o),
  .act_mode(act_mode), .act_tap(act_tap), .act_hi(act_hi), .act_lo(act_lo),
  .init_q(init_w), .cnt_q(cnt_w)
);

// File: tb/sim_prog_clk_div.sv
`timescale 1ns/1ps
module sim_prog_clk_div;
  localparam int CNT_W = 8;
  localparam int CTR_W = 16;
  localparam int TAP_W = $clog2(CTR_W);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic [TAP_W-1:0] tap;
  logic [CNT_W-1:0] hi, lo;
  logic             div_clk, rise;

  int n_checks = 0;
  int n_fail   = 0;
  int mism     = 0;
  int n_rise   = 0;
  bit mon_prev = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prog_clk_div #(.CNT_W(CNT_W), .CTR_W(CTR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tap_i(tap),
    .hi_i(hi), .lo_i(lo), .clk_div_o(div_clk), .rise_o(rise)
  );

  // Pulse monitor for R7, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rise != (div_clk && !mon_prev)) mism++;
      if (rise) n_rise++;
      mon_prev = div_clk;
    end else begin
      mon_prev = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input int t, input int h, input int l);
    mode = m; tap = TAP_W'(t); hi = CNT_W'(h); lo = CNT_W'(l);
  endtask

  // Waits for a falling edge (unless already at one), then returns the
  // low-run and high-run lengths; ends on the next fall sample.
  task automatic measure(input bit at_fall, output int lo_n, output int hi_n);
    bit prev;
    if (!at_fall) begin
      prev = div_clk;
      forever begin
        @(negedge clk);
        if (prev && !div_clk) break;
        prev = div_clk;
      end
    end
    lo_n = 1;
    forever begin
      @(negedge clk);
      if (div_clk) break;
      lo_n++;
    end
    hi_n = 1;
    forever begin
      @(negedge clk);
      if (!div_clk) break;
      hi_n++;
    end
  endtask

  task automatic wait_high();
    forever begin
      @(negedge clk);
      if (div_clk) break;
    end
  endtask

  task automatic expect_period(input string req, input int exp_lo, input int exp_hi, input bit at_fall);
    int l, h;
    measure(at_fall, l, h);
    check(l == exp_lo, {req, " low run"}, l, exp_lo);
    check(h == exp_hi, {req, " high run"}, h, exp_hi);
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    setup(2'd2, 0, 3, 2);
    repeat (3) @(negedge clk);
    check(div_clk == 1'b0, "R1 output in reset", int'(div_clk), 0);
    check(rise == 1'b0, "R1 pulse in reset", int'(rise), 0);
    rst_n = 1'b1;
    n = 1;
    forever begin
      @(negedge clk);
      if (div_clk) break;
      n++;
    end
    check(n == 3, "R1 first low run after reset", n, 3);
  endtask

  task automatic t_int();
    setup(2'd2, 0, 3, 5);
    expect_period("R4 int 5/3", 5, 3, 1'b0);
    expect_period("R4 int 5/3 repeat", 5, 3, 1'b1);
    setup(2'd3, 0, 4, 2);
    expect_period("R4 mode3 2/4", 2, 4, 1'b0);
  endtask

  task automatic t_half();
    setup(2'd0, 3, 5, 7);
    expect_period("R2 half-rate", 1, 1, 1'b0);
    expect_period("R2 half-rate repeat", 1, 1, 1'b1);
  endtask

  task automatic t_pow2();
    setup(2'd1, 0, 9, 9);
    expect_period("R3 tap0", 1, 1, 1'b0);
    setup(2'd1, 2, 9, 9);
    expect_period("R3 tap2", 4, 4, 1'b0);
    setup(2'd1, 3, 9, 9);
    expect_period("R3 tap3", 8, 8, 1'b0);
    expect_period("R3 tap3 repeat", 8, 8, 1'b1);
  endtask

  task automatic t_zero();
    setup(2'd2, 0, 0, 0);
    expect_period("R5 both zero", 1, 1, 1'b0);
    setup(2'd2, 0, 0, 3);
    expect_period("R5 high zero", 3, 1, 1'b0);
    setup(2'd2, 0, 2, 0);
    expect_period("R5 low zero", 1, 2, 1'b0);
  endtask

  task automatic t_runtime();
    int h, l;
    setup(2'd2, 0, 4, 4);
    expect_period("R6 sync 4/4", 4, 4, 1'b0);
    // change during high phase
    wait_high();
    @(negedge clk);
    setup(2'd2, 0, 2, 6);
    h = 2;
    forever begin
      @(negedge clk);
      if (!div_clk) break;
      h++;
    end
    check(h == 4, "R6 high run keeps old count", h, 4);
    expect_period("R6 new after high-phase change", 6, 2, 1'b1);
    // change during low phase (now 2 cycles into a 6-cycle low)
    @(negedge clk);
    setup(2'd2, 0, 3, 1);
    l = 2;
    forever begin
      @(negedge clk);
      if (div_clk) break;
      l++;
    end
    check(l == 6, "R6 low run keeps old count", l, 6);
    h = 1;
    forever begin
      @(negedge clk);
      if (!div_clk) break;
      h++;
    end
    check(h == 2, "R6 high run after low-phase change", h, 2);
    expect_period("R6 new after low-phase change", 1, 3, 1'b1);
  endtask

  task automatic t_tap_change();
    int h;
    setup(2'd1, 1, 0, 0);
    expect_period("R8 tap1 sync", 2, 2, 1'b0);
    wait_high();
    setup(2'd1, 3, 0, 0);
    h = 1;
    forever begin
      @(negedge clk);
      if (!div_clk) break;
      h++;
    end
    check(h == 2, "R8 old tap finishes period", h, 2);
    expect_period("R8 new tap full phases", 8, 8, 1'b1);
  endtask

  task automatic t_async_reset();
    int n;
    setup(2'd2, 0, 4, 4);
    wait_high();
    #1 rst_n = 1'b0;
    #0.5;
    check(div_clk == 1'b0, "R1 reset mid-period forces low", int'(div_clk), 0);
    check(rise == 1'b0, "R1 reset mid-period clears pulse", int'(rise), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 1;
    forever begin
      @(negedge clk);
      if (div_clk) break;
      n++;
    end
    check(n == 5, "R1 low run after second reset", n, 5);
  endtask

  initial begin
    t_reset();
    t_int();
    t_half();
    t_pow2();
    t_zero();
    t_runtime();
    t_tap_change();
    t_async_reset();
    repeat (4) @(negedge clk);
    check(mism == 0, "R7 pulse matches every rising edge", mism, 0);
    check(n_rise > 20, "R7 pulses seen", n_rise, 21);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule